// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This block is the digital control core of a serial video reclocker that accepts several bit rates. Around it sit an analog clock-recovery loop, a VCO and phase detectors. They see the block only through a 3-bit candidate-rate output, a loop-lock input and a frequency-in-tolerance input. The block decides which rate the loop should try, when that attempt counts as a lock, and how the output stage should route the data.

In automatic mode the controller walks through a fixed cyclic list of candidate rates. It waits a programmable dwell time on each candidate before moving on. When the loop reports lock, the controller holds the current candidate. The lock output asserts only once the lock report has persisted for a programmable qualification count. In manual mode the 3-bit code is an input and fixes the single rate the loop may try. The same code lines serve as an output in automatic mode, where they carry the most recently locked rate, with an enable that marks the bus direction. The controller also produces an SD/HD indication and the bypass and mute selects for the output path.

A parameter chooses the HD-capable variant, which includes the high rate, or the SD-only variant, which omits it.

Top module: `rate_lock_ctrl`

## Requirements
- R1: In automatic mode the candidate starts at code 000 after reset. It advances after `dwell_limit` consecutive cycles spent searching without lock, in the order 000, 001, 010, 011, 100, 101 and then back to 000. The code values mean 143, 177, 270, 360, 540 and 1485 Mb/s.
- R2: With `HD_EN`=0 the code 101 never appears as a candidate. The automatic search wraps from 100 straight to 000, and a manual code of 101 is ignored.
- R3: While `asi_protect` is high in automatic mode, code 001 is skipped. If the candidate is 001 when `asi_protect` is high, the controller moves to 010 at the next edge, so no lock at 001 is possible.
- R4: In manual mode the candidate equals the last valid `rate_cmd` and never advances on dwell timeouts. Codes 110 and 111 are ignored.
- R5: `rate_code_oe` equals `auto_mode`. `rate_code_o` shows the rate of the most recent lock, and is 000 before any lock has occurred.
- R6: `locked_o` rises right after the edge at which `loop_lock_i` and `freq_ok_i` have both been sampled high on `qual_limit` consecutive edges. Any gap in that run restarts the count.
- R7: When `loop_lock_i` or `freq_ok_i` falls while the controller is qualifying or locked, the controller returns to the search state and `locked_o` is low after the next edge. The candidate does not change.
- R8: `sd_flag_o` is high only while locked to a code from 000 to 100. It is low when locked at 101 and whenever the controller is unlocked.
- R9: `path_bypass_o` is high whenever `bypass_i` is high. With `bypass_i` low, it follows `autobypass_i` only while `locked_o` is low.
- R10: `path_mute_o` equals `mute_i` when the path is not bypassed, and is low whenever `path_bypass_o` is high.
- R11: A change of `auto_mode`, or of an accepted manual code, restarts acquisition. `locked_o` is low after the next edge. Entering automatic mode restarts the search at 000.
- R12: During reset the candidate and the code output are 000, and `locked_o` and `sd_flag_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 selects automatic search, 0 selects manual rate |
| asi_protect | input | 1 | Skip the 177 Mb/s candidate in automatic search |
| rate_cmd | input | 3 | Manual rate code (input side of the code bus) |
| rate_code_o | output | 3 | Most recently locked rate (output side of the code bus) |
| rate_code_oe | output | 1 | Drive enable for the code bus |
| dwell_limit | input | DW | Search cycles per candidate before advancing |
| qual_limit | input | QW | Consecutive good cycles needed before lock |
| loop_lock_i | input | 1 | Clock-recovery loop reports lock |
| freq_ok_i | input | 1 | Rate error within tolerance |
| cand_rate_o | output | 3 | Candidate rate driven to the loop |
| locked_o | output | 1 | Qualified lock |
| sd_flag_o | output | 1 | Locked at a standard-definition rate |
| bypass_i | input | 1 | Force output bypass |
| autobypass_i | input | 1 | Bypass while unlocked |
| mute_i | input | 1 | Mute request for the retimed output |
| path_bypass_o | output | 1 | Output path bypass select |
| path_mute_o | output | 1 | Output path mute select |

## Verification
The bench follows the candidate along the full wrap of both variants. A design that wrapped at the wrong point, or that offered 101 in the SD-only variant, shows a wrong code at one exact dwell boundary. It counts qualification edges exactly, both after an interrupted run and at the boundary of `qual_limit`, so an off-by-one or a counter that is not cleared changes the cycle at which lock rises. It raises `asi_protect` while the candidate sits at 001 with the loop reporting lock, which catches a skip applied only on advance. It checks that the mute request disappears under both kinds of bypass and that autobypass releases once lock is reached.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_QUAL   = 2'd1,
    ST_LOCK   = 2'd2
  } acq_st_e;

  localparam logic [2:0] RC_143  = 3'd0;
  localparam logic [2:0] RC_177  = 3'd1;
  localparam logic [2:0] RC_270  = 3'd2;
  localparam logic [2:0] RC_360  = 3'd3;
  localparam logic [2:0] RC_540  = 3'd4;
  localparam logic [2:0] RC_1485 = 3'd5;

  // Next candidate in the cyclic search list.
  function automatic logic [2:0] rate_after(input logic [2:0] cur,
                                            input logic       skip177,
                                            input logic       hd);
    logic [2:0] r;
    case (cur)
      RC_143:  r = skip177 ? RC_270 : RC_177;
      RC_177:  r = RC_270;
      RC_270:  r = RC_360;
      RC_360:  r = RC_540;
      RC_540:  r = hd ? RC_1485 : RC_143;
      default: r = RC_143;
    endcase
    return r;
  endfunction

  // A manual code is accepted only if the variant supports it.
  function automatic logic code_valid(input logic [2:0] c, input logic hd);
    return (c <= RC_540) || (hd && (c == RC_1485));
  endfunction

endpackage

// File: rtl/rlc_rate_seq.sv
module rlc_rate_seq
  import rlc_pkg::*;
#(
  parameter bit HD_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_mode,
  input  logic       asi_protect,
  input  logic [2:0] rate_cmd,
  input  logic       adv_i,
  input  logic       lock_enter_i,
  output logic [2:0] cand_o,
  output logic [2:0] last_lock_o,
  output logic       restart_o
);

  logic       mode_q;
  logic [2:0] man_q, man_d;
  logic [2:0] cand_q, cand_d;
  logic [2:0] last_q, last_d;
  logic       cmd_ok, mode_chg, cmd_chg, asi_kick;

  always_comb begin
    cmd_ok    = code_valid(rate_cmd, HD_EN);
    mode_chg  = (auto_mode != mode_q);
    cmd_chg   = !auto_mode && cmd_ok && (rate_cmd != man_q);
    asi_kick  = auto_mode && asi_protect && (cand_q == RC_177);
    restart_o = mode_chg || cmd_chg || asi_kick;

    man_d  = cmd_ok ? rate_cmd : man_q;
    last_d = lock_enter_i ? cand_q : last_q;

    if (mode_chg)
      cand_d = auto_mode ? RC_143 : (cmd_ok ? rate_cmd : man_q);
    else if (cmd_chg)
      cand_d = rate_cmd;
    else if (asi_kick || (adv_i && auto_mode))
      cand_d = rate_after(cand_q, asi_protect, HD_EN);
    else
      cand_d = cand_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      man_q  <= RC_143;
      cand_q <= RC_143;
      last_q <= RC_143;
    end else begin
      mode_q <= auto_mode;
      man_q  <= man_d;
      cand_q <= cand_d;
      last_q <= last_d;
    end
  end

  assign cand_o      = cand_q;
  assign last_lock_o = last_q;

  // R4: a steady manual command never moves the candidate
  a_r4_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && !mode_q && (rate_cmd == cand_q)) |=> (cand_q == $past(cand_q)));

  generate
    if (!HD_EN) begin : g_sd_only
      // R2: the HD code is never offered in the SD-only variant
      a_r2_no_hd_code: assert property (@(posedge clk) disable iff (!rst_n)
        cand_q != RC_1485);
    end
  endgenerate

endmodule

// File: rtl/rlc_acq_fsm.sv
module rlc_acq_fsm
  import rlc_pkg::*;
#(
  parameter int DW = 16,
  parameter int QW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          loop_lock_i,
  input  logic          freq_ok_i,
  input  logic [DW-1:0] dwell_limit_i,
  input  logic [QW-1:0] qual_limit_i,
  output logic          adv_o,
  output logic          lock_enter_o,
  output logic          locked_o
);

  localparam logic [DW:0] DONE_D = {{DW{1'b0}}, 1'b1};
  localparam logic [QW:0] DONE_Q = {{QW{1'b0}}, 1'b1};

  acq_st_e       st_q, st_d;
  logic [DW-1:0] dwell_q, dwell_d;
  logic [QW-1:0] qual_q, qual_d;
  logic          good, dwell_hit, qual_hit;

  always_comb begin
    good      = loop_lock_i && freq_ok_i;
    dwell_hit = ({1'b0, dwell_q} + DONE_D) >= {1'b0, dwell_limit_i};
    qual_hit  = ({1'b0, qual_q} + DONE_Q) >= {1'b0, qual_limit_i};

    st_d         = st_q;
    dwell_d      = dwell_q;
    qual_d       = qual_q;
    adv_o        = 1'b0;
    lock_enter_o = 1'b0;

    if (restart_i) begin
      st_d    = ST_SEARCH;
      dwell_d = '0;
      qual_d  = '0;
    end else begin
      case (st_q)
        ST_SEARCH: begin
          if (good) begin
            dwell_d = '0;
            qual_d  = qual_q + 1'b1;
            if (qual_hit) begin
              st_d         = ST_LOCK;
              lock_enter_o = 1'b1;
            end else begin
              st_d = ST_QUAL;
            end
          end else if (dwell_hit) begin
            adv_o   = 1'b1;
            dwell_d = '0;
          end else begin
            dwell_d = dwell_q + 1'b1;
          end
        end
        ST_QUAL: begin
          if (!good) begin
            st_d    = ST_SEARCH;
            qual_d  = '0;
            dwell_d = '0;
          end else if (qual_hit) begin
            st_d         = ST_LOCK;
            lock_enter_o = 1'b1;
          end else begin
            qual_d = qual_q + 1'b1;
          end
        end
        default: begin
          if (!good) begin
            st_d    = ST_SEARCH;
            qual_d  = '0;
            dwell_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SEARCH;
      dwell_q <= '0;
      qual_q  <= '0;
    end else begin
      st_q    <= st_d;
      dwell_q <= dwell_d;
      qual_q  <= qual_d;
    end
  end

  assign locked_o = (st_q == ST_LOCK);

  // R6: lock only rises after a good sample
  a_r6_lock_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(loop_lock_i && freq_ok_i));

  // R7: a bad sample while locked drops lock at the next edge
  a_r7_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !(loop_lock_i && freq_ok_i)) |=> !locked_o);

  // R11: a restart always clears lock
  a_r11_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !locked_o);

  // R1: the search only advances while unlocked
  a_r1_adv_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> !locked_o);

endmodule

// File: rtl/rlc_out_path.sv
module rlc_out_path
  import rlc_pkg::*;
(
  input  logic       locked_i,
  input  logic [2:0] cand_i,
  input  logic       bypass_i,
  input  logic       autobypass_i,
  input  logic       mute_i,
  output logic       sd_flag_o,
  output logic       path_bypass_o,
  output logic       path_mute_o
);

  always_comb begin
    path_bypass_o = bypass_i || (autobypass_i && !locked_i);
    path_mute_o   = mute_i && !path_bypass_o;
    sd_flag_o     = locked_i && (cand_i != RC_1485);
  end

endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rlc_pkg::*;
#(
  parameter bit HD_EN = 1'b1,
  parameter int DW    = 16,
  parameter int QW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_mode,
  input  logic          asi_protect,
  input  logic [2:0]    rate_cmd,
  output logic [2:0]    rate_code_o,
  output logic          rate_code_oe,
  input  logic [DW-1:0] dwell_limit,
  input  logic [QW-1:0] qual_limit,
  input  logic          loop_lock_i,
  input  logic          freq_ok_i,
  output logic [2:0]    cand_rate_o,
  output logic          locked_o,
  output logic          sd_flag_o,
  input  logic          bypass_i,
  input  logic          autobypass_i,
  input  logic          mute_i,
  output logic          path_bypass_o,
  output logic          path_mute_o
);

  logic adv, lock_enter, restart;

  rlc_rate_seq #(.HD_EN(HD_EN)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .auto_mode    (auto_mode),
    .asi_protect  (asi_protect),
    .rate_cmd     (rate_cmd),
    .adv_i        (adv),
    .lock_enter_i (lock_enter),
    .cand_o       (cand_rate_o),
    .last_lock_o  (rate_code_o),
    .restart_o    (restart)
  );

  rlc_acq_fsm #(.DW(DW), .QW(QW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (restart),
    .loop_lock_i   (loop_lock_i),
    .freq_ok_i     (freq_ok_i),
    .dwell_limit_i (dwell_limit),
    .qual_limit_i  (qual_limit),
    .adv_o         (adv),
    .lock_enter_o  (lock_enter),
    .locked_o      (locked_o)
  );

  rlc_out_path u_out (
    .locked_i      (locked_o),
    .cand_i        (cand_rate_o),
    .bypass_i      (bypass_i),
    .autobypass_i  (autobypass_i),
    .mute_i        (mute_i),
    .sd_flag_o     (sd_flag_o),
    .path_bypass_o (path_bypass_o),
    .path_mute_o   (path_mute_o)
  );

  assign rate_code_oe = auto_mode;

  // R3: no lock at 177 Mb/s one edge after protection is seen in auto mode
  a_r3_no_177_under_asi: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && asi_protect) |=> !(locked_o && (cand_rate_o == RC_177)));

  // R8: SD flag only while locked to an SD rate
  a_r8_sd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sd_flag_o |-> (locked_o && (cand_rate_o != RC_1485)));

  // R9: forced bypass wins
  a_r9_bypass_force: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |-> path_bypass_o);

  // R9: autobypass releases once locked
  a_r9_autobypass_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (autobypass_i && !bypass_i && locked_o) |-> !path_bypass_o);

  // R10: mute has no effect in bypass
  a_r10_no_mute_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    path_bypass_o |-> !path_mute_o);

endmodule

// File: tb/test_rate_lock_ctrl.sv
module test_rate_lock_ctrl;

  localparam int DW = 16;
  localparam int QW = 12;
  localparam int DWELL = 8;
  localparam int QUAL  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          auto_mode, asi_protect, loop_lock, freq_ok;
  logic          bypass, autobypass, mute;
  logic [2:0]    rate_cmd;
  logic [DW-1:0] dwell_limit;
  logic [QW-1:0] qual_limit;

  logic [2:0] code_h, cand_h, code_s, cand_s;
  logic       oe_h, locked_h, sd_h, byp_h, mute_h;
  logic       oe_s, locked_s, sd_s, byp_s, mute_s;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rate_lock_ctrl #(.HD_EN(1'b1), .DW(DW), .QW(QW)) i_rate_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .asi_protect(asi_protect),
    .rate_cmd(rate_cmd), .rate_code_o(code_h), .rate_code_oe(oe_h),
    .dwell_limit(dwell_limit), .qual_limit(qual_limit),
    .loop_lock_i(loop_lock), .freq_ok_i(freq_ok), .cand_rate_o(cand_h),
    .locked_o(locked_h), .sd_flag_o(sd_h), .bypass_i(bypass),
    .autobypass_i(autobypass), .mute_i(mute),
    .path_bypass_o(byp_h), .path_mute_o(mute_h));

  rate_lock_ctrl #(.HD_EN(1'b0), .DW(DW), .QW(QW)) i_rate_lock_ctrl_sd (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .asi_protect(asi_protect),
    .rate_cmd(rate_cmd), .rate_code_o(code_s), .rate_code_oe(oe_s),
    .dwell_limit(dwell_limit), .qual_limit(qual_limit),
    .loop_lock_i(loop_lock), .freq_ok_i(freq_ok), .cand_rate_o(cand_s),
    .locked_o(locked_s), .sd_flag_o(sd_s), .bypass_i(bypass),
    .autobypass_i(autobypass), .mute_i(mute),
    .path_bypass_o(byp_s), .path_mute_o(mute_s));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic am, input logic asi, input logic [2:0] cmd);
    @(negedge clk);
    rst_n = 1'b0;
    auto_mode = am; asi_protect = asi; rate_cmd = cmd;
    loop_lock = 1'b0; freq_ok = 1'b1;
    bypass = 1'b0; autobypass = 1'b0; mute = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1, 1'b0, 3'd0);
    rst_n = 1'b0;
    tick(2);
    chk("R12 cand in reset", cand_h, 0);
    chk("R12 code in reset", code_h, 0);
    chk("R12 locked in reset", locked_h, 0);
    chk("R12 sd flag in reset", sd_h, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_search_order();
    do_reset(1'b1, 1'b0, 3'd0);
    tick(DWELL - 1);
    chk("R1 still 000 before dwell end", cand_h, 0);
    tick(1);
    chk("R1 advance to 001", cand_h, 1);
    tick(DWELL); chk("R1 advance to 010", cand_h, 2);
    tick(DWELL); chk("R1 advance to 011", cand_h, 3);
    tick(DWELL); chk("R1 advance to 100", cand_h, 4);
    chk("R2 sd variant at 100", cand_s, 4);
    tick(DWELL);
    chk("R1 advance to 101", cand_h, 5);
    chk("R2 sd variant wraps to 000", cand_s, 0);
    tick(DWELL);
    chk("R1 wrap to 000", cand_h, 0);
    chk("R5 oe in auto", oe_h, 1);
  endtask

  task automatic t_asi_skip();
    do_reset(1'b1, 1'b1, 3'd0);
    tick(DWELL);
    chk("R3 skip 001 on advance", cand_h, 2);
    do_reset(1'b1, 1'b0, 3'd0);
    tick(DWELL);
    chk("R3 at 001 before protect", cand_h, 1);
    loop_lock = 1'b1;
    asi_protect = 1'b1;
    tick(1);
    chk("R3 kicked off 001", cand_h, 2);
    chk("R3 not locked after kick", locked_h, 0);
    tick(QUAL);
    chk("R3 lock lands on 010", code_h, 2);
    chk("R3 locked at 010", locked_h, 1);
    loop_lock = 1'b0; asi_protect = 1'b0;
  endtask

  task automatic t_lock_qual();
    do_reset(1'b1, 1'b0, 3'd0);
    tick(2 * DWELL);
    chk("R1 at 010 before lock", cand_h, 2);
    loop_lock = 1'b1;
    tick(QUAL - 1);
    chk("R6 not yet locked", locked_h, 0);
    chk("R5 code before any lock", code_h, 0);
    tick(1);
    chk("R6 locked after qual count", locked_h, 1);
    chk("R5 code shows locked rate", code_h, 2);
    chk("R8 sd flag at 270", sd_h, 1);
    tick(3 * DWELL);
    chk("R1 no advance while locked", cand_h, 2);
    loop_lock = 1'b0;
    tick(1);
    chk("R7 lock drops", locked_h, 0);
    chk("R8 sd flag low unlocked", sd_h, 0);
    chk("R5 code keeps last lock", code_h, 2);
    chk("R7 candidate unchanged", cand_h, 2);
    // interrupted run restarts the count
    loop_lock = 1'b1; tick(QUAL - 1);
    loop_lock = 1'b0; tick(1);
    loop_lock = 1'b1; tick(QUAL - 1);
    chk("R6 gap restarts count", locked_h, 0);
    tick(1);
    chk("R6 locked after fresh run", locked_h, 1);
    freq_ok = 1'b0;
    tick(1);
    chk("R7 freq error drops lock", locked_h, 0);
    freq_ok = 1'b1; loop_lock = 1'b0;
  endtask

  task automatic t_hd_flag();
    do_reset(1'b1, 1'b0, 3'd0);
    tick(5 * DWELL);
    chk("R1 reach 101", cand_h, 5);
    loop_lock = 1'b1;
    tick(QUAL);
    chk("R8 locked at 1485", locked_h, 1);
    chk("R8 sd flag low at 1485", sd_h, 0);
    chk("R5 code 101", code_h, 5);
    loop_lock = 1'b0;
  endtask

  task automatic t_manual();
    do_reset(1'b0, 1'b0, 3'd3);
    tick(1);
    chk("R4 manual cand", cand_h, 3);
    chk("R5 oe low in manual", oe_h, 0);
    tick(3 * DWELL);
    chk("R4 no search in manual", cand_h, 3);
    rate_cmd = 3'd6; tick(2);
    chk("R4 code 110 ignored", cand_h, 3);
    rate_cmd = 3'd5; tick(1);
    chk("R4 code 101 accepted hd", cand_h, 5);
    chk("R2 code 101 ignored sd", cand_s, 3);
    rate_cmd = 3'd2; tick(1);
    chk("R4 manual 010", cand_h, 2);
    loop_lock = 1'b1;
    tick(QUAL);
    chk("R4 manual locks", locked_h, 1);
    rate_cmd = 3'd4; tick(1);
    chk("R11 code change clears lock", locked_h, 0);
    chk("R11 new manual cand", cand_h, 4);
    tick(QUAL);
    chk("R11 relock at new code", locked_h, 1);
    auto_mode = 1'b1; tick(1);
    chk("R11 mode change clears lock", locked_h, 0);
    chk("R11 auto restarts at 000", cand_h, 0);
    loop_lock = 1'b0;
  endtask

  task automatic t_out_path();
    do_reset(1'b1, 1'b0, 3'd0);
    mute = 1'b1; tick(1);
    chk("R10 mute passes", mute_h, 1);
    chk("R9 no bypass", byp_h, 0);
    autobypass = 1'b1; tick(1);
    chk("R9 autobypass unlocked", byp_h, 1);
    chk("R10 mute ignored in bypass", mute_h, 0);
    loop_lock = 1'b1; tick(QUAL);
    chk("R9 locked for autobypass", locked_h, 1);
    chk("R9 autobypass released", byp_h, 0);
    chk("R10 mute when locked", mute_h, 1);
    bypass = 1'b1; tick(1);
    chk("R9 bypass overrides", byp_h, 1);
    chk("R10 mute ignored forced bypass", mute_h, 0);
    autobypass = 1'b0; tick(1);
    chk("R9 bypass alone", byp_h, 1);
    bypass = 1'b0; mute = 1'b0; loop_lock = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    dwell_limit = DW'(DWELL);
    qual_limit  = QW'(QUAL);
    auto_mode = 1'b1; asi_protect = 1'b0; rate_cmd = 3'd0;
    loop_lock = 1'b0; freq_ok = 1'b1;
    bypass = 1'b0; autobypass = 1'b0; mute = 1'b0;
    t_reset_state();
    t_search_order();
    t_asi_skip();
    t_lock_qual();
    t_hd_flag();
    t_manual();
    t_out_path();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule